// File: doc/BRIEF.md
# Pointer Upper-Bound Check Unit

This unit sits in the execution stage and carries out two pointer upper-bound check operations. The decoder supplies the third opcode byte that follows the shared escape bytes F2 0F. It also supplies an operand address, which is either a register value or an effective address that has already been computed, and the upper-bound field read from a bound register. Alongside these come the decode context: processor mode, bound-register index, lock-prefix and address-size-prefix indications, and the default size of the code segment.

One variant stores the bound in inverted form and flips it before comparing. The other uses the bound as stored. The unit first checks the encoding rules, so an illegal form gives an undefined-opcode fault. A legal form whose address lies above the bound gives a bound-range fault and writes the status code 01H.

The unit never touches memory or condition flags. Its result appears one clock after the input strobe.

Top module: `ubound_checker`

## Requirements
- R1: With opcode byte 8'h1A, the bound input is bitwise inverted before the compare.
- R2: With opcode byte 8'h1B, the bound input is compared as given.
- R3: The check fails only when the address is strictly greater than the effective bound, compared as unsigned. An equal address passes.
- R4: A failed check raises `range_fault` and `stat_we` in the same cycle, with `stat_data` equal to 8'h01.
- R5: A set `lock_pfx` raises `ud_fault` instead of the check.
- R6: With `mode` equal to 3 (64-bit), a `bnd_idx` of 4 to 15 raises `ud_fault`. In any other mode only `bnd_idx[2:0]` is used, and a value of 4 to 7 raises `ud_fault`.
- R7: Mode encoding is 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit. In modes 0 and 1, a clear `asize_pfx` (16-bit addressing) raises `ud_fault`. In mode 2, `ud_fault` is raised when `asize_pfx` equals `cs_32`. Mode 3 has no address-size rule.
- R8: In mode 3 all 64 bits are compared. In other modes only bits 31:0 of the address and of the effective bound are compared.
- R9: When `ud_fault` is raised, neither `range_fault` nor `stat_we` is raised.
- R10: `out_valid` pulses exactly one cycle after each `in_valid` cycle. All fault and write outputs are single-cycle pulses that occur only with `out_valid`. After reset every output pulse is low.
- R11: An opcode byte other than 8'h1A or 8'h1B raises `ud_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| opcode | input | 8 | Third opcode byte |
| addr | input | 64 | Operand or effective address |
| bound | input | 64 | Stored upper-bound field |
| mode | input | 2 | Processor mode |
| bnd_idx | input | 4 | Bound-register index, bit 3 from REX |
| lock_pfx | input | 1 | Lock prefix present |
| asize_pfx | input | 1 | Address-size prefix present |
| cs_32 | input | 1 | Code segment defaults to 32-bit |
| out_valid | output | 1 | Result strobe |
| range_fault | output | 1 | Bound-range fault pulse |
| ud_fault | output | 1 | Undefined-opcode fault pulse |
| stat_we | output | 1 | Status register write enable |
| stat_data | output | 8 | Status value to write |

## Verification
The assertions check the following properties on every cycle:
- the one-cycle response to each strobe;
- that the two fault kinds never occur together;
- that the status write always accompanies a range fault;
- that a lock prefix always yields an undefined-opcode fault.

Whether each individual compare gives the right answer can only be shown by the bench scenarios. These include the equal-bound and one-above cases for both opcodes, high-half differences outside 64-bit mode, each index and address-size rule per mode, and random operand streams.

// File: rtl/ubound_checker.sv
module ubound_checker #(
  parameter int          AW          = 64,
  parameter int          NW          = 32,
  parameter logic [7:0]  OP_INV      = 8'h1A,
  parameter logic [7:0]  OP_DIR      = 8'h1B,
  parameter logic [7:0]  STATUS_CODE = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] bound,
  input  logic [1:0]    mode,
  input  logic [3:0]    bnd_idx,
  input  logic          lock_pfx,
  input  logic          asize_pfx,
  input  logic          cs_32,
  output logic          out_valid,
  output logic          range_fault,
  output logic          ud_fault,
  output logic          stat_we,
  output logic [7:0]    stat_data
);
  localparam logic [1:0] M_REAL = 2'd0;
  localparam logic [1:0] M_V86  = 2'd1;
  localparam logic [1:0] M_PROT = 2'd2;
  localparam logic [1:0] M_LONG = 2'd3;

  logic [AW-1:0] ub_eff;
  logic          wide, over, bad_op, bad_idx, bad_asz, undef;

  assign wide    = (mode == M_LONG);
  assign ub_eff  = (opcode == OP_INV) ? ~bound : bound;
  assign over    = wide ? (addr > ub_eff) : (addr[NW-1:0] > ub_eff[NW-1:0]);
  assign bad_op  = (opcode != OP_INV) && (opcode != OP_DIR);
  assign bad_idx = wide ? (bnd_idx > 4'd3) : bnd_idx[2];

  always_comb begin
    case (mode)
      M_REAL, M_V86: bad_asz = !asize_pfx;
      M_PROT:        bad_asz = (asize_pfx == cs_32);
      default:       bad_asz = 1'b0;
    endcase
  end

  assign undef     = lock_pfx || bad_op || bad_idx || bad_asz;
  assign stat_data = STATUS_CODE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      ud_fault    <= 1'b0;
      range_fault <= 1'b0;
      stat_we     <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      ud_fault    <= in_valid && undef;
      range_fault <= in_valid && !undef && over;
      stat_we     <= in_valid && !undef && over;
    end
  end
endmodule

// File: rtl/ubound_checker_sva.sv
module ubound_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic lock_pfx,
  input logic out_valid,
  input logic range_fault,
  input logic ud_fault,
  input logic stat_we
);
  a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (range_fault || ud_fault || stat_we) |-> out_valid);
  a_r4_write_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (stat_we == range_fault));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ud_fault && range_fault));
  a_r5_lock_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lock_pfx) |=> (ud_fault && !range_fault));
endmodule

bind ubound_checker ubound_checker_sva chk (.*);

// File: tb/ubound_checker_test.sv
module ubound_checker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h1B;
  logic [63:0] addr = '0, bound = '0;
  logic [1:0]  mode = 2'd3;
  logic [3:0]  bnd_idx = '0;
  logic        lock_pfx = 1'b0, asize_pfx = 1'b0, cs_32 = 1'b0;
  logic        out_valid, range_fault, ud_fault, stat_we;
  logic [7:0]  stat_data;

  int vectors = 0, fails = 0;
  bit e_v = 0, e_ud = 0, e_rf = 0;
  string e_tag = "R10 reset state";

  always #(CLK_PERIOD/2) clk = ~clk;

  ubound_checker uut (.*);

  function automatic void model(input bit v, input logic [7:0] op, input longint unsigned a,
                                input longint unsigned b, input int md, input int idx,
                                input bit lk, input bit asz, input bit c32);
    longint unsigned lim;
    bit u;
    u = lk;
    if (op != 8'h1A && op != 8'h1B) u = 1;
    if (md == 3) begin if (idx >= 4) u = 1; end
    else if ((idx % 8) >= 4) u = 1;
    if ((md == 0 || md == 1) && !asz) u = 1;
    if (md == 2 && asz == c32) u = 1;
    lim = (op == 8'h1A) ? ~b : b;
    if (md != 3) begin a = a & 64'hFFFF_FFFF; lim = lim & 64'hFFFF_FFFF; end
    e_v  = v;
    e_ud = v && u;
    e_rf = v && !u && (a > lim);
  endfunction

  task automatic compare();
    vectors++;
    if (out_valid !== e_v || ud_fault !== e_ud || range_fault !== e_rf ||
        stat_we !== e_rf || stat_data !== 8'h01) begin
      fails++;
      $display("FAIL %s: got v=%0b ud=%0b rf=%0b we=%0b sd=%02h exp v=%0b ud=%0b rf=%0b we=%0b sd=01",
               e_tag, out_valid, ud_fault, range_fault, stat_we, stat_data, e_v, e_ud, e_rf, e_rf);
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [7:0] op, input logic [63:0] a,
                      input logic [63:0] b, input logic [1:0] md, input logic [3:0] idx,
                      input bit lk, input bit asz, input bit c32);
    @(negedge clk);
    compare();
    in_valid = v; opcode = op; addr = a; bound = b; mode = md; bnd_idx = idx;
    lock_pfx = lk; asize_pfx = asz; cs_32 = c32;
    model(v, op, a, b, md, idx, lk, asz, c32);
    e_tag = tag;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2 / R3: equal passes, one above fails
    step("R2 equal passes",        1, 8'h1B, 64'h1000, 64'h1000, 3, 0, 0, 0, 0);
    step("R2 above fails",         1, 8'h1B, 64'h1001, 64'h1000, 3, 1, 0, 0, 0);
    step("R1 inverted equal",      1, 8'h1A, 64'h1000, ~64'h1000, 3, 2, 0, 0, 0);
    step("R1 inverted above",      1, 8'h1A, 64'h1001, ~64'h1000, 3, 3, 0, 0, 0);
    step("R3 unsigned top",        1, 8'h1B, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 3, 0, 0, 0, 0);
    step("R4 status on fail",      1, 8'h1B, 64'h20, 64'h10, 2, 0, 0, 1, 0);
    step("R10 idle",               0, 8'h1B, 64'h20, 64'h10, 3, 0, 0, 0, 0);
    // R8 width
    step("R8 high half ignored",   1, 8'h1B, 64'hFFFF_0000_0000_0010, 64'h20, 2, 0, 0, 0, 1);
    step("R8 64-bit high half",    1, 8'h1B, 64'hFFFF_0000_0000_0010, 64'h20, 3, 0, 0, 0, 0);
    step("R8 inverted low half",   1, 8'h1A, 64'h0000_0001_0000_0005, 64'hFFFF_FFFF_FFFF_FFFA, 0, 0, 0, 1, 0);
    // R5 R6 R7 R9 R11
    step("R5 lock",                1, 8'h1B, 64'h20, 64'h10, 3, 0, 1, 0, 0);
    step("R6 idx4 32-bit",         1, 8'h1B, 64'h20, 64'h10, 2, 4, 0, 0, 1);
    step("R6 idx8 32-bit ok",      1, 8'h1B, 64'h20, 64'h10, 2, 8, 0, 0, 1);
    step("R6 idx8 64-bit",         1, 8'h1B, 64'h20, 64'h10, 3, 8, 0, 0, 0);
    step("R6 idx15 64-bit",        1, 8'h1A, 64'h0, 64'h0, 3, 15, 0, 0, 0);
    step("R7 prot no pfx cs16",    1, 8'h1B, 64'h1, 64'h10, 2, 0, 0, 0, 0);
    step("R7 prot pfx cs32",       1, 8'h1B, 64'h1, 64'h10, 2, 0, 0, 1, 1);
    step("R7 prot pfx cs16 ok",    1, 8'h1B, 64'h1, 64'h10, 2, 0, 0, 1, 0);
    step("R7 real no pfx",         1, 8'h1B, 64'h1, 64'h10, 0, 0, 0, 0, 1);
    step("R7 v86 no pfx",          1, 8'h1B, 64'h1, 64'h10, 1, 0, 0, 0, 0);
    step("R7 v86 pfx ok",          1, 8'h1B, 64'h1, 64'h10, 1, 0, 0, 1, 0);
    step("R9 undef hides fail",    1, 8'h1B, 64'h99, 64'h10, 0, 5, 0, 1, 0);
    step("R11 bad opcode",         1, 8'h1C, 64'h1, 64'h10, 3, 0, 0, 0, 0);
    step("R11 bad opcode 00",      1, 8'h00, 64'h1, 64'h10, 3, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 5 == 0) b = (i % 2 == 0) ? a : ~a;
      step("R3 random", ($urandom % 4) != 0, ($urandom % 8 == 0) ? 8'h1C : (($urandom % 2 != 0) ? 8'h1A : 8'h1B),
           a, b, 2'($urandom), ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 4),
           ($urandom % 16) == 0, 1'($urandom), 1'($urandom));
    end
    step("R10 drain", 0, 8'h1B, 64'h0, 64'h0, 3, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule